// File: doc/BRIEF.md
# Signed Setpoint DAC Write Controller

This block turns one write command into the full set of strobes that a downstream time-slot serial engine needs to update a DAC. Two targets are supported. Main output DACs take a signed setpoint and a 2-bit channel number. The setpoint is sent as a clamped magnitude, and its sign is held in a separate polarity image. Trim DACs take an 8-bit value and a logical channel number from 0 to 10. The block remaps that logical number to a physical address before sending.

For each accepted command, the block first programs slot records 2 to 5 of the serial engine. It then writes the polarity image, pushes one 32-bit packet into the engine's FIFO and clears the engine's underflow flag. After that it releases slot 0 and waits for the engine to report underflow. Finally it re-arms slot 0 and follows a two-step handshake on the engine's feedback byte until the pass has ended. The two slots after the real data always address a channel that does not exist, so the serial clock keeps running cleanly after the real data.

A copy of the last value sent to each trim channel can be read at any time. Commands offered while a transaction is in flight are held off through the ready signal and are never lost.

Top module: `dac_wr_ctrl`

## Requirements
- R1: For a main write, a negative setpoint sets bit `main_chan_i` of the polarity image, and zero or a positive setpoint clears that bit. Other bits keep their value, and trim writes leave the image unchanged. The image goes out on `pol_o` with one `pol_wr_o` strobe per transaction. It resets to 0.
- R2: The main-DAC magnitude is the absolute value of the setpoint, limited to 0x1FFF. This includes the most negative input value.
- R3: The main packet is 0x0F000000 | 0x00004000 | (main_chan_i[0] << 15) | magnitude.
- R4: Slot records use this layout: [8] end-of-list, [7] input-buffer select, [6:5] receive source (0 none, 1 SD2, 2 SD3), [4] transmit, [3:2] FIFO byte, [1:0] word select (0 none, 1 WS1, 2 WS2, 3 WS3). For a main write, slots 2, 3, 4 and 5 get transmit=1 with FIFO bytes 1, 0, 3 and 2. Slots 2 and 3 use WS1 when main_chan_i[1]=1 and WS2 otherwise. Slots 4 and 5 use WS3, and only slot 5 sets end-of-list.
- R5: Trim logical channels 0 to 10 map to physical addresses 10, 9, 8, 3, 2, 7, 6, 1, 0, 5, 4. The trim packet is (physical << 8) | value.
- R6: For a trim write, slots 2 to 5 follow the R4 pattern except for word select: slots 2 and 3 use WS3, and slots 4 and 5 use WS1.
- R7: Each transaction emits strobes in this order: slot writes 2, 3, 4, 5; then polarity; then FIFO; then flag clear. Next comes the slot-0 release record (transmit, SD3, input-buffer select, no end-of-list). It then waits for `underflow_i` and writes the slot-0 arm record (transmit, FIFO byte 2, SD2, input-buffer select, end-of-list).
- R8: After arming, if `fb_msb_i` is non-zero the block waits until it reads zero. It then writes the slot-0 final record (SD3, input-buffer select, end-of-list, no transmit) and waits until `fb_msb_i` is non-zero again.
- R9: `rd_data_o` returns the last value written to trim channel `rd_chan_i`. It returns 0 for a channel that has never been written and for channels above 10.
- R10: `busy_o` rises in the cycle after a command is accepted. It falls in the cycle after `fb_msb_i` reads non-zero in the final wait. `cmd_ready_o` is low while busy, so a waiting command is held and is taken later.
- R11: A trim command with a logical channel above 10 produces a one-cycle `err_o` in the cycle after it is accepted. It sends nothing, stays idle and does not update readback.
- R12: After reset, `busy_o`=0, `cmd_ready_o`=1, `err_o`=0, `pol_o`=0, and all readback values are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Command can be taken this cycle |
| cmd_trim_i | input | 1 | 1 = trim write, 0 = main write |
| main_chan_i | input | 2 | Main DAC channel |
| main_value_i | input | 16 | Signed main setpoint |
| trim_chan_i | input | 4 | Trim logical channel |
| trim_value_i | input | 8 | Trim value |
| busy_o | output | 1 | Transaction in flight |
| err_o | output | 1 | Invalid trim channel pulse |
| pol_wr_o | output | 1 | Polarity image write strobe |
| pol_o | output | 4 | Polarity image |
| slot_wr_o | output | 1 | Slot record write strobe |
| slot_idx_o | output | 3 | Slot number being written |
| slot_rec_o | output | 9 | Slot record |
| fifo_wr_o | output | 1 | FIFO packet write strobe |
| fifo_data_o | output | 32 | Serial packet |
| flag_clr_o | output | 1 | Underflow flag clear strobe |
| underflow_i | input | 1 | Engine FIFO underflow flag |
| fb_msb_i | input | 8 | Most significant byte of the engine feedback word |
| rd_chan_i | input | 4 | Trim readback channel |
| rd_data_o | output | 8 | Trim readback value |

## Verification
A wrong slot counter or FIFO-byte decode shows up as a wrong slot record within the first four cycles after acceptance, before any packet leaves the block. An error in the sign or clamp path shows up in the polarity strobe and the FIFO word only a few cycles later. A fault in the completion handshake is the slowest to become visible. It can appear as `busy_o` dropping while the feedback byte is still zero, or as a final record issued too early. That behaviour only shows once the feedback byte changes, and it differs between on-time and late trap timing, so both timings are driven.

// File: rtl/dac_wr_pkg.sv
package dac_wr_pkg;
  typedef enum logic [1:0] {WS_NONE = 2'd0, WS_1 = 2'd1, WS_2 = 2'd2, WS_3 = 2'd3} ws_e;
  typedef enum logic [1:0] {RX_NONE = 2'd0, RX_SD2 = 2'd1, RX_SD3 = 2'd2, RX_RSV = 2'd3} rx_e;

  typedef struct packed {
    logic       eos;
    logic       sib;
    rx_e        rx;
    logic       xmit;
    logic [1:0] fifo_byte;
    ws_e        ws;
  } slot_rec_t;

  localparam int SLOT_REC_W = $bits(slot_rec_t);
  localparam int SLOT_IDX_W = 3;
  localparam int PKT_W      = 32;

  localparam logic [SLOT_IDX_W-1:0] FIRST_SLOT = 3'd2;
  localparam logic [SLOT_IDX_W-1:0] PAD_SLOT   = 3'd4;
  localparam logic [SLOT_IDX_W-1:0] LAST_SLOT  = 3'd5;

  function automatic slot_rec_t mk_rec(logic eos, logic sib, rx_e rx, logic xmit,
                                       logic [1:0] fb, ws_e ws);
    slot_rec_t r;
    r.eos = eos; r.sib = sib; r.rx = rx; r.xmit = xmit; r.fifo_byte = fb; r.ws = ws;
    return r;
  endfunction

  // logical trim channel -> physical trim address
  function automatic logic [3:0] trim_phys(logic [3:0] lch);
    case (lch)
      4'd0:    trim_phys = 4'd10;
      4'd1:    trim_phys = 4'd9;
      4'd2:    trim_phys = 4'd8;
      4'd3:    trim_phys = 4'd3;
      4'd4:    trim_phys = 4'd2;
      4'd5:    trim_phys = 4'd7;
      4'd6:    trim_phys = 4'd6;
      4'd7:    trim_phys = 4'd1;
      4'd8:    trim_phys = 4'd0;
      4'd9:    trim_phys = 4'd5;
      4'd10:   trim_phys = 4'd4;
      default: trim_phys = 4'd0;
    endcase
  endfunction
endpackage

// File: rtl/dac_cmd_fmt.sv
module dac_cmd_fmt
  import dac_wr_pkg::*;
#(
  parameter int SETPT_W = 16,
  parameter int MAG_W   = 13,
  parameter int MCH_W   = 2,
  parameter int N_TRIM  = 11,
  parameter int TCH_W   = 4,
  parameter int TRIM_W  = 8
) (
  input  logic               trim_i,
  input  logic [MCH_W-1:0]   main_chan_i,
  input  logic [SETPT_W-1:0] main_value_i,
  input  logic [TCH_W-1:0]   trim_chan_i,
  input  logic [TRIM_W-1:0]  trim_value_i,
  input  logic [(1<<MCH_W)-1:0] pol_cur_i,
  output logic [(1<<MCH_W)-1:0] pol_next_o,
  output logic [PKT_W-1:0]   pkt_o,
  output ws_e                ws_tgt_o,
  output ws_e                ws_pad_o,
  output logic               trim_bad_o
);
  localparam logic [SETPT_W:0] ABS_MAX  = (SETPT_W+1)'((1 << MAG_W) - 1);
  localparam logic [SETPT_W:0] ONE      = (SETPT_W+1)'(1);
  localparam logic [PKT_W-1:0] PAD_WORD = 32'h0F00_0000;
  localparam logic [PKT_W-1:0] CTL_BIT  = 32'h0000_4000;
  localparam int               ADDR_BIT = 15;
  localparam logic [TCH_W-1:0] TRIM_MAX = TCH_W'(N_TRIM - 1);

  logic             neg;
  logic [SETPT_W:0] ext, absv;
  logic [MAG_W-1:0] mag;
  logic [3:0]       phys;

  assign neg  = main_value_i[SETPT_W-1];
  assign ext  = {main_value_i[SETPT_W-1], main_value_i};
  assign absv = neg ? (~ext + ONE) : ext;
  assign mag  = (absv > ABS_MAX) ? ABS_MAX[MAG_W-1:0] : absv[MAG_W-1:0];
  assign phys = trim_phys(4'(trim_chan_i));

  assign trim_bad_o = trim_chan_i > TRIM_MAX;

  always_comb begin
    pol_next_o = pol_cur_i;
    if (!trim_i) pol_next_o[main_chan_i] = neg;
  end

  always_comb begin
    if (trim_i) begin
      pkt_o    = (PKT_W'(phys) << TRIM_W) | PKT_W'(trim_value_i);
      ws_tgt_o = WS_3;
      ws_pad_o = WS_1;
    end else begin
      pkt_o    = PAD_WORD | CTL_BIT | (PKT_W'(main_chan_i[0]) << ADDR_BIT) | PKT_W'(mag);
      ws_tgt_o = main_chan_i[1] ? WS_1 : WS_2;
      ws_pad_o = WS_3;
    end
  end
endmodule

// File: rtl/dac_trim_store.sv
module dac_trim_store #(
  parameter int N_TRIM = 11,
  parameter int TCH_W  = 4,
  parameter int TRIM_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [TCH_W-1:0]  wchan_i,
  input  logic [TRIM_W-1:0] wdata_i,
  input  logic [TCH_W-1:0]  rchan_i,
  output logic [TRIM_W-1:0] rdata_o
);
  logic [TRIM_W-1:0] val_q [N_TRIM];

  for (genvar g = 0; g < N_TRIM; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               val_q[g] <= '0;
      else if (we_i && wchan_i == TCH_W'(g))     val_q[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < N_TRIM; i++)
      if (rchan_i == TCH_W'(i)) rdata_o = val_q[i];
  end
endmodule

// File: rtl/dac_send_seq.sv
module dac_send_seq
  import dac_wr_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  ws_e                   ws_tgt_i,
  input  ws_e                   ws_pad_i,
  input  logic                  underflow_i,
  input  logic [7:0]            fb_msb_i,
  output logic                  busy_o,
  output logic                  slot_wr_o,
  output logic [SLOT_IDX_W-1:0] slot_idx_o,
  output slot_rec_t             slot_rec_o,
  output logic                  pol_wr_o,
  output logic                  fifo_wr_o,
  output logic                  flag_clr_o
);
  typedef enum logic [3:0] {
    ST_IDLE, ST_SLOTS, ST_POL, ST_FIFO, ST_CLR, ST_REL,
    ST_WUF, ST_ARM, ST_CHK, ST_WZ, ST_FIN, ST_WNZ
  } st_e;

  st_e                   st_q, st_d;
  logic [SLOT_IDX_W-1:0] cnt_q, cnt_d;
  logic                  fb_set;

  assign fb_set = |fb_msb_i;
  assign busy_o = st_q != ST_IDLE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= FIRST_SLOT;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  always_comb begin
    st_d       = st_q;
    cnt_d      = cnt_q;
    slot_wr_o  = 1'b0;
    slot_idx_o = '0;
    slot_rec_o = '0;
    pol_wr_o   = 1'b0;
    fifo_wr_o  = 1'b0;
    flag_clr_o = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        cnt_d = FIRST_SLOT;
        if (start_i) st_d = ST_SLOTS;
      end
      ST_SLOTS: begin
        slot_wr_o  = 1'b1;
        slot_idx_o = cnt_q;
        // FIFO byte order 1,0,3,2 for slots 2..5
        slot_rec_o = mk_rec(cnt_q == LAST_SLOT, 1'b0, RX_NONE, 1'b1,
                            {cnt_q[2], ~cnt_q[0]},
                            (cnt_q < PAD_SLOT) ? ws_tgt_i : ws_pad_i);
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST_SLOT) st_d = ST_POL;
      end
      ST_POL:  begin pol_wr_o   = 1'b1; st_d = ST_FIFO; end
      ST_FIFO: begin fifo_wr_o  = 1'b1; st_d = ST_CLR;  end
      ST_CLR:  begin flag_clr_o = 1'b1; st_d = ST_REL;  end
      ST_REL: begin
        slot_wr_o  = 1'b1;
        slot_rec_o = mk_rec(1'b0, 1'b1, RX_SD3, 1'b1, 2'd0, WS_NONE);
        st_d       = ST_WUF;
      end
      ST_WUF: if (underflow_i) st_d = ST_ARM;
      ST_ARM: begin
        slot_wr_o  = 1'b1;
        slot_rec_o = mk_rec(1'b1, 1'b1, RX_SD2, 1'b1, 2'd2, WS_NONE);
        st_d       = ST_CHK;
      end
      ST_CHK: st_d = fb_set ? ST_WZ : ST_FIN;
      ST_WZ:  if (!fb_set) st_d = ST_FIN;
      ST_FIN: begin
        slot_wr_o  = 1'b1;
        slot_rec_o = mk_rec(1'b1, 1'b1, RX_SD3, 1'b0, 2'd0, WS_NONE);
        st_d       = ST_WNZ;
      end
      ST_WNZ: if (fb_set) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/dac_wr_ctrl.sv
module dac_wr_ctrl
  import dac_wr_pkg::*;
#(
  parameter int SETPT_W = 16,
  parameter int MAG_W   = 13,
  parameter int MCH_W   = 2,
  parameter int N_TRIM  = 11,
  parameter int TCH_W   = 4,
  parameter int TRIM_W  = 8,
  localparam int N_MAIN = 1 << MCH_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cmd_valid_i,
  output logic                  cmd_ready_o,
  input  logic                  cmd_trim_i,
  input  logic [MCH_W-1:0]      main_chan_i,
  input  logic [SETPT_W-1:0]    main_value_i,
  input  logic [TCH_W-1:0]      trim_chan_i,
  input  logic [TRIM_W-1:0]     trim_value_i,
  output logic                  busy_o,
  output logic                  err_o,
  output logic                  pol_wr_o,
  output logic [N_MAIN-1:0]     pol_o,
  output logic                  slot_wr_o,
  output logic [SLOT_IDX_W-1:0] slot_idx_o,
  output logic [SLOT_REC_W-1:0] slot_rec_o,
  output logic                  fifo_wr_o,
  output logic [PKT_W-1:0]      fifo_data_o,
  output logic                  flag_clr_o,
  input  logic                  underflow_i,
  input  logic [7:0]            fb_msb_i,
  input  logic [TCH_W-1:0]      rd_chan_i,
  output logic [TRIM_W-1:0]     rd_data_o
);
  logic              accept, bad, start;
  logic [N_MAIN-1:0] pol_q, pol_next;
  logic [PKT_W-1:0]  pkt_q, pkt_d;
  ws_e               ws_tgt_q, ws_pad_q, ws_tgt_d, ws_pad_d;
  logic              trim_bad, err_q;
  slot_rec_t         rec;

  dac_cmd_fmt #(
    .SETPT_W(SETPT_W), .MAG_W(MAG_W), .MCH_W(MCH_W),
    .N_TRIM(N_TRIM), .TCH_W(TCH_W), .TRIM_W(TRIM_W)
  ) u_fmt (
    .trim_i      (cmd_trim_i),
    .main_chan_i (main_chan_i),
    .main_value_i(main_value_i),
    .trim_chan_i (trim_chan_i),
    .trim_value_i(trim_value_i),
    .pol_cur_i   (pol_q),
    .pol_next_o  (pol_next),
    .pkt_o       (pkt_d),
    .ws_tgt_o    (ws_tgt_d),
    .ws_pad_o    (ws_pad_d),
    .trim_bad_o  (trim_bad)
  );

  assign cmd_ready_o = ~busy_o;
  assign accept      = cmd_valid_i & cmd_ready_o;
  assign bad         = cmd_trim_i & trim_bad;
  assign start       = accept & ~bad;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pol_q    <= '0;
      pkt_q    <= '0;
      ws_tgt_q <= WS_NONE;
      ws_pad_q <= WS_NONE;
      err_q    <= 1'b0;
    end else begin
      err_q <= accept & bad;
      if (start) begin
        pol_q    <= pol_next;
        pkt_q    <= pkt_d;
        ws_tgt_q <= ws_tgt_d;
        ws_pad_q <= ws_pad_d;
      end
    end
  end

  dac_send_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .ws_tgt_i   (ws_tgt_q),
    .ws_pad_i   (ws_pad_q),
    .underflow_i(underflow_i),
    .fb_msb_i   (fb_msb_i),
    .busy_o     (busy_o),
    .slot_wr_o  (slot_wr_o),
    .slot_idx_o (slot_idx_o),
    .slot_rec_o (rec),
    .pol_wr_o   (pol_wr_o),
    .fifo_wr_o  (fifo_wr_o),
    .flag_clr_o (flag_clr_o)
  );

  dac_trim_store #(.N_TRIM(N_TRIM), .TCH_W(TCH_W), .TRIM_W(TRIM_W)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (start & cmd_trim_i),
    .wchan_i(trim_chan_i),
    .wdata_i(trim_value_i),
    .rchan_i(rd_chan_i),
    .rdata_o(rd_data_o)
  );

  assign slot_rec_o  = rec;
  assign pol_o       = pol_q;
  assign fifo_data_o = pkt_q;
  assign err_o       = err_q;
endmodule

// File: rtl/dac_wr_ctrl_chk.sv
module dac_wr_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmd_valid_i,
  input logic       cmd_ready_o,
  input logic       busy_o,
  input logic       err_o,
  input logic       pol_wr_o,
  input logic       slot_wr_o,
  input logic [2:0] slot_idx_o,
  input logic [8:0] slot_rec_o,
  input logic       fifo_wr_o,
  input logic       flag_clr_o,
  input logic [7:0] fb_msb_i
);
  logic fin_wr;
  assign fin_wr = slot_wr_o && slot_idx_o == 3'd0 && slot_rec_o[8] &&
                  slot_rec_o[6:5] == 2'd2 && !slot_rec_o[4];

  assert_strobe_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pol_wr_o, fifo_wr_o, flag_clr_o, slot_wr_o}));

  assert_pol_then_fifo_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pol_wr_o |=> fifo_wr_o);

  assert_fifo_then_clr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_wr_o |=> flag_clr_o);

  assert_first_slot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (slot_wr_o && slot_idx_o == 3'd2));

  assert_start_on_valid_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(cmd_valid_i));

  assert_done_on_fb_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> ($past(fb_msb_i) != 8'h00));

  assert_fin_after_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_wr |-> ($past(fb_msb_i) == 8'h00));

  assert_err_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !busy_o);
endmodule

bind dac_wr_ctrl dac_wr_ctrl_chk u_chk (.*);

// File: tb/tb_dac_wr_ctrl.sv
`timescale 1ns/1ps
module tb_dac_wr_ctrl;
  typedef struct packed {
    logic        trim;
    logic [3:0]  chan;
    logic [15:0] val;
    logic        late;
    logic [31:0] pkt;
    logic [3:0]  pol;
    logic [1:0]  ws_t;
    logic [1:0]  ws_p;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'd0,  16'd100,   1'b0, 32'h0F00_4064, 4'h0, 2'd2, 2'd3},
    '{1'b0, 4'd1,  16'hFFFB,  1'b1, 32'h0F00_C005, 4'h2, 2'd2, 2'd3},
    '{1'b0, 4'd2,  16'h1FFF,  1'b0, 32'h0F00_5FFF, 4'h2, 2'd1, 2'd3},
    '{1'b0, 4'd3,  16'hB1E0,  1'b0, 32'h0F00_DFFF, 4'hA, 2'd1, 2'd3},
    '{1'b0, 4'd1,  16'h2328,  1'b1, 32'h0F00_DFFF, 4'h8, 2'd2, 2'd3},
    '{1'b0, 4'd3,  16'h8000,  1'b0, 32'h0F00_DFFF, 4'h8, 2'd1, 2'd3},
    '{1'b1, 4'd0,  16'h00A5,  1'b0, 32'h0000_0AA5, 4'h8, 2'd3, 2'd1},
    '{1'b1, 4'd10, 16'h003C,  1'b1, 32'h0000_043C, 4'h8, 2'd3, 2'd1},
    '{1'b1, 4'd3,  16'h0001,  1'b0, 32'h0000_0301, 4'h8, 2'd3, 2'd1},
    '{1'b0, 4'd0,  16'h0000,  1'b0, 32'h0F00_4000, 4'h8, 2'd2, 2'd3}
  };
  localparam int EXP_EV [10] = '{12, 13, 14, 15, 1, 2, 3, 10, 10, 10};
  localparam logic [8:0] REC_REL = {1'b0, 1'b1, 2'd2, 1'b1, 2'd0, 2'd0};
  localparam logic [8:0] REC_ARM = {1'b1, 1'b1, 2'd1, 1'b1, 2'd2, 2'd0};
  localparam logic [8:0] REC_FIN = {1'b1, 1'b1, 2'd2, 1'b0, 2'd0, 2'd0};

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready, cmd_trim = 1'b0;
  logic [1:0] main_chan = '0;
  logic [15:0] main_value = '0;
  logic [3:0] trim_chan = '0, rd_chan = '0;
  logic [7:0] trim_value = '0, rd_data, fb_msb = 8'hFF;
  logic busy, err, pol_wr, slot_wr, fifo_wr, flag_clr, underflow = 1'b0;
  logic [3:0] pol;
  logic [2:0] slot_idx;
  logic [8:0] slot_rec;
  logic [31:0] fifo_data;

  always #2.5 clk = ~clk;

  dac_wr_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_trim_i(cmd_trim), .main_chan_i(main_chan), .main_value_i(main_value),
    .trim_chan_i(trim_chan), .trim_value_i(trim_value), .busy_o(busy), .err_o(err),
    .pol_wr_o(pol_wr), .pol_o(pol), .slot_wr_o(slot_wr), .slot_idx_o(slot_idx),
    .slot_rec_o(slot_rec), .fifo_wr_o(fifo_wr), .fifo_data_o(fifo_data),
    .flag_clr_o(flag_clr), .underflow_i(underflow), .fb_msb_i(fb_msb),
    .rd_chan_i(rd_chan), .rd_data_o(rd_data)
  );

  int total = 0, fails = 0;
  int ev_n = 0, s0_n = 0, fifo_n = 0, pol_n = 0;
  int ev_log [1024];
  logic [8:0] s0_rec [256];
  logic [31:0] fifo_hist [256];
  logic [8:0] slot_cap [6];
  logic [3:0] pol_cap = '0;
  logic late = 1'b0;
  int uf_cnt = 0, z_cnt = 0, ff_cnt = 0;

  // serial engine model, driven and sampled on the falling edge
  always @(negedge clk) begin
    if (uf_cnt > 0) begin
      uf_cnt--;
      if (uf_cnt == 0) begin underflow = 1'b1; if (late) fb_msb = 8'h00; end
    end
    if (z_cnt > 0) begin z_cnt--; if (z_cnt == 0) fb_msb = 8'h00; end
    if (ff_cnt > 0) begin ff_cnt--; if (ff_cnt == 0) fb_msb = 8'hFF; end
    if (slot_wr) begin
      ev_log[ev_n] = 10 + int'(slot_idx); ev_n++;
      if (slot_idx <= 3'd5) slot_cap[slot_idx] = slot_rec;
      if (slot_idx == 3'd0) begin
        s0_rec[s0_n] = slot_rec; s0_n++;
        if (slot_rec == REC_REL) uf_cnt = 3;
        else if (slot_rec == REC_ARM && !late) z_cnt = 4;
        else if (slot_rec == REC_FIN) ff_cnt = 3;
      end
    end
    if (pol_wr)   begin ev_log[ev_n] = 1; ev_n++; pol_cap = pol; pol_n++; end
    if (fifo_wr)  begin ev_log[ev_n] = 2; ev_n++; fifo_hist[fifo_n] = fifo_data; fifo_n++; end
    if (flag_clr) begin ev_log[ev_n] = 3; ev_n++; underflow = 1'b0; end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic t, input logic [3:0] ch, input logic [15:0] v);
    @(negedge clk);
    cmd_trim = t; main_chan = ch[1:0]; main_value = v; trim_chan = ch; trim_value = v[7:0];
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (busy && n < 400) begin @(negedge clk); n++; end
    if (busy) chk("R10 completion timeout", 32'(busy), 32'd0);
  endtask

  initial begin
    #(200000 * 5);
    total++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 busy in reset", 32'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 busy", 32'(busy), 0);
    chk("R12 ready", 32'(cmd_ready), 1);
    chk("R12 err", 32'(err), 0);
    chk("R12 pol", 32'(pol), 0);
    rd_chan = 4'd0; #0.1;
    chk("R12 readback", 32'(rd_data), 0);

    for (int i = 0; i < NV; i++) begin
      automatic vec_t v = VECS[i];
      automatic int eb = ev_n, sb = s0_n, fb = fifo_n;
      automatic logic mism = 1'b0;
      late = v.late;
      drive(v.trim, v.chan, v.val);
      chk("R10 busy after accept", 32'(busy), 1);
      wait_done();
      chk("R8 feedback set at done", 32'(fb_msb != 8'h00), 1);
      chk(v.trim ? "R5 trim packet" : "R3/R2 main packet", fifo_hist[fb], v.pkt);
      chk("R1 polarity image", 32'(pol_cap), 32'(v.pol));
      chk(v.trim ? "R6 slot2" : "R4 slot2", 32'(slot_cap[2]), 32'({1'b0, 1'b0, 2'd0, 1'b1, 2'd1, v.ws_t}));
      chk(v.trim ? "R6 slot3" : "R4 slot3", 32'(slot_cap[3]), 32'({1'b0, 1'b0, 2'd0, 1'b1, 2'd0, v.ws_t}));
      chk(v.trim ? "R6 slot4" : "R4 slot4", 32'(slot_cap[4]), 32'({1'b0, 1'b0, 2'd0, 1'b1, 2'd3, v.ws_p}));
      chk(v.trim ? "R6 slot5" : "R4 slot5", 32'(slot_cap[5]), 32'({1'b1, 1'b0, 2'd0, 1'b1, 2'd2, v.ws_p}));
      if (ev_n - eb != 10) mism = 1'b1;
      else for (int k = 0; k < 10; k++) if (ev_log[eb + k] != EXP_EV[k]) mism = 1'b1;
      chk("R7 strobe order", 32'(mism), 0);
      chk("R7 slot0 release", 32'(s0_rec[sb]), 32'(REC_REL));
      chk("R7 slot0 arm", 32'(s0_rec[sb + 1]), 32'(REC_ARM));
      chk("R8 slot0 final", 32'(s0_rec[sb + 2]), 32'(REC_FIN));
    end

    // R9 readback
    rd_chan = 4'd0;  #0.1; chk("R9 trim ch0",  32'(rd_data), 32'h A5);
    rd_chan = 4'd10; #0.1; chk("R9 trim ch10", 32'(rd_data), 32'h3C);
    rd_chan = 4'd3;  #0.1; chk("R9 trim ch3",  32'(rd_data), 32'h01);
    rd_chan = 4'd5;  #0.1; chk("R9 unwritten ch5", 32'(rd_data), 32'h00);

    // R11 invalid trim channel
    begin
      automatic int fb = fifo_n, pb = pol_n, eb = ev_n;
      drive(1'b1, 4'd11, 16'h0099);
      chk("R11 err pulse", 32'(err), 1);
      chk("R11 stays idle", 32'(busy), 0);
      @(negedge clk);
      chk("R11 err one cycle", 32'(err), 0);
      repeat (5) @(negedge clk);
      chk("R11 nothing sent", 32'(ev_n - eb + fifo_n - fb + pol_n - pb), 0);
      rd_chan = 4'd11; #0.1; chk("R9 out of range readback", 32'(rd_data), 0);
    end

    // R10 stall: second command held while busy
    begin
      automatic int fb = fifo_n;
      late = 1'b0;
      drive(1'b0, 4'd0, 16'd7);
      @(negedge clk);
      cmd_trim = 1'b1; trim_chan = 4'd5; trim_value = 8'h77; cmd_valid = 1'b1;
      chk("R10 ready low while busy", 32'(cmd_ready), 0);
      while (!cmd_ready) @(negedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
      chk("R10 held command started", 32'(busy), 1);
      wait_done();
      chk("R10 first packet", fifo_hist[fb], 32'h0F00_4007);
      chk("R10 held packet sent", fifo_hist[fb + 1], 32'h0000_0777);
      rd_chan = 4'd5; #0.1; chk("R9 trim ch5", 32'(rd_data), 32'h77);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule